// File: doc/BRIEF.md
# Push-Pull Phase Generator with Selectable Overlap or Dead Time

This block turns the switching-period clock of a buck stage into the two alternating gate commands of a push-pull stage. A one-cycle pulse on `osc_tick_i` marks each period edge. At every such edge the active output hands over to the other one, so each output runs at half the period rate with a nominal 50% duty cycle.

Each handover is surrounded by a transition window. The window's length is the programmed count plus a fixed offset that depends on the mode. A mode input chooses what the window does. In dead-time mode, both outputs are off during the window. In overlap mode, both outputs are on during the window, so an inductor fed from the buck stage always has a path.

The outputs keep alternating for as long as the reference-good input stays high. This holds even when the buck stage itself is disabled. They stop, and the phase returns to a known start, only when reference-good drops.

Top module: `pp_phase_gen`

## Requirements
- R1: In reset, and whenever the block is inactive, both outputs are low. After `ref_ok_i` rises, the outputs stay low until the first sampled tick. That first tick makes `push_o` high alone, with no transition window.
- R2: Each later tick, sampled with `ref_ok_i` high, swaps which output is active. Push and pull therefore alternate, one period each.
- R3: When `overlap_i` is 0 at a tick (dead-time mode), both outputs are low for `interval_i + 3` cycles. These cycles start in the cycle right after the sampling edge. The incoming output then goes high.
- R4: When `overlap_i` is 1 at a tick (overlap mode), both outputs are high for `interval_i + 1` cycles. These cycles start in the cycle right after the sampling edge. After that, only the incoming output stays high.
- R5: A low `ref_ok_i` sampled at an edge drives both outputs low from the next cycle. Ticks sampled while `ref_ok_i` is low have no effect. A tick in the same cycle as a low `ref_ok_i` is ignored.
- R6: `overlap_i` and `interval_i` are sampled only at the tick edge. Changing them between ticks has no effect on the outputs.
- R7: A tick that arrives while a window is still open starts a new window. The new window uses the mode and length sampled at that tick, and the phase still swaps.
- R8: While the block is active and no window is open, exactly one output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_ok_i | input | 1 | Reference-good; low stops and resets the phase generator |
| osc_tick_i | input | 1 | One-cycle pulse at each period edge of the buck stage |
| overlap_i | input | 1 | 1 selects overlap (both on), 0 selects dead time (both off) |
| interval_i | input | IVAL_W (8) | Programmable part of the window length, in clock cycles |
| push_o | output | 1 | Push drive command |
| pull_o | output | 1 | Pull drive command |

## Verification
Two functions can collide in the same cycle. First, a tick can arrive while the previous window is still counting. The bench provokes this with windows longer than the tick spacing, and with a window exactly equal to it. It then checks that the outputs follow the freshly sampled mode and that the phase still alternates. Second, a tick can coincide with the drop of reference-good. The bench drives both in one cycle and expects all-low outputs, followed by a restart on push. Expected levels for every cycle come from the tick count, the cycle offset since the tick and the window length computed in the bench.

// File: rtl/pp_phase_pkg.sv
package pp_phase_pkg;
  typedef enum logic {
    PH_PUSH = 1'b0,
    PH_PULL = 1'b1
  } phase_e;
endpackage

// File: rtl/pp_phase_toggle.sv
module pp_phase_toggle
  import pp_phase_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ref_ok_i,
  input  logic   tick_i,
  output phase_e phase_o,
  output logic   active_o,
  output logic   handover_o
);
  phase_e phase_q;
  logic   active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_PULL;
      active_q <= 1'b0;
    end else if (!ref_ok_i) begin
      phase_q  <= PH_PULL;
      active_q <= 1'b0;
    end else if (tick_i) begin
      active_q <= 1'b1;
      phase_q  <= active_q ? phase_e'(~phase_q) : PH_PUSH;
    end
  end

  // a real handover (not the start-up tick) opens a window
  assign handover_o = ref_ok_i & tick_i & active_q;
  assign phase_o    = phase_q;
  assign active_o   = active_q;

  a_r2_phase_swaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ref_ok_i && active_q) |=> (phase_q != $past(phase_q)));
  a_r1_start_on_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ref_ok_i && !active_q) |=> (phase_q == PH_PUSH && active_q));
endmodule

// File: rtl/pp_window_timer.sv
module pp_window_timer #(
  parameter int unsigned IVAL_W   = 8,
  parameter int unsigned OVL_OFS  = 1,
  parameter int unsigned DEAD_OFS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_ok_i,
  input  logic              tick_i,
  input  logic              handover_i,
  input  logic              overlap_i,
  input  logic [IVAL_W-1:0] interval_i,
  output logic              ovl_o,
  output logic              open_o
);
  localparam int unsigned LEN_W = IVAL_W + 2;
  localparam logic [LEN_W-1:0] OVL_ADD  = LEN_W'(OVL_OFS);
  localparam logic [LEN_W-1:0] DEAD_ADD = LEN_W'(DEAD_OFS);

  logic [LEN_W-1:0] cnt_q, len_d;
  logic             ovl_q;
  logic             sample;

  assign sample = ref_ok_i & tick_i;
  assign len_d  = LEN_W'(interval_i) + (overlap_i ? OVL_ADD : DEAD_ADD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovl_q <= 1'b0;
    end else if (!ref_ok_i) begin
      cnt_q <= '0;
    end else if (sample) begin
      ovl_q <= overlap_i;
      cnt_q <= handover_i ? len_d : '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ovl_o  = ovl_q;
  assign open_o = (cnt_q != '0);

  a_r6_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample |=> $stable(ovl_q));
  a_r3_countdown: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_ok_i && !sample && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r5_window_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ok_i |=> (cnt_q == '0));
endmodule

// File: rtl/pp_drive_mux.sv
module pp_drive_mux
  import pp_phase_pkg::*;
(
  input  phase_e phase_i,
  input  logic   active_i,
  input  logic   open_i,
  input  logic   ovl_i,
  output logic   push_o,
  output logic   pull_o
);
  always_comb begin
    push_o = 1'b0;
    pull_o = 1'b0;
    if (active_i) begin
      if (open_i) begin
        push_o = ovl_i;
        pull_o = ovl_i;
      end else begin
        push_o = (phase_i == PH_PUSH);
        pull_o = (phase_i == PH_PULL);
      end
    end
  end
endmodule

// File: rtl/pp_phase_gen.sv
module pp_phase_gen
  import pp_phase_pkg::*;
#(
  parameter int unsigned IVAL_W   = 8,
  parameter int unsigned OVL_OFS  = 1,
  parameter int unsigned DEAD_OFS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ref_ok_i,
  input  logic              osc_tick_i,
  input  logic              overlap_i,
  input  logic [IVAL_W-1:0] interval_i,
  output logic              push_o,
  output logic              pull_o
);
  phase_e phase;
  logic   active, handover, ovl, win_open;

  pp_phase_toggle u_toggle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_ok_i   (ref_ok_i),
    .tick_i     (osc_tick_i),
    .phase_o    (phase),
    .active_o   (active),
    .handover_o (handover)
  );

  pp_window_timer #(
    .IVAL_W   (IVAL_W),
    .OVL_OFS  (OVL_OFS),
    .DEAD_OFS (DEAD_OFS)
  ) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_ok_i   (ref_ok_i),
    .tick_i     (osc_tick_i),
    .handover_i (handover),
    .overlap_i  (overlap_i),
    .interval_i (interval_i),
    .ovl_o      (ovl),
    .open_o     (win_open)
  );

  pp_drive_mux u_mux (
    .phase_i  (phase),
    .active_i (active),
    .open_i   (win_open),
    .ovl_i    (ovl),
    .push_o   (push_o),
    .pull_o   (pull_o)
  );

  a_r5_ref_low_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_ok_i |=> (!push_o && !pull_o));
  a_r8_single_outside_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !win_open) |-> (push_o ^ pull_o));
  a_r3_dead_gap_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open && !ovl) |-> (!push_o && !pull_o));
  a_r4_overlap_both_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (win_open && ovl && active) |-> (push_o && pull_o));
endmodule

// File: tb/pp_phase_gen_bench.sv
module pp_phase_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OVL_OFS    = 1;
  localparam int DEAD_OFS   = 3;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_ok = 1'b0;
  logic       tick = 1'b0;
  logic       ovl = 1'b0;
  logic [7:0] ival = 8'd0;
  logic       push, pull;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_phase_gen u_pp_phase_gen (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .ref_ok_i   (ref_ok),
    .osc_tick_i (tick),
    .overlap_i  (ovl),
    .interval_i (ival),
    .push_o     (push),
    .pull_o     (pull)
  );

  task automatic chk(input string req, input logic ep, input logic el);
    n_chk++;
    if (push !== ep || pull !== el) begin
      n_fail++;
      $display("FAIL %s: push/pull=%b%b expected %b%b at %0t", req, push, pull, ep, el, $time);
    end
  endtask

  // ticks spaced S cycles; tick n samples mode mpat[n%8] and length iv
  task automatic run_seq(input int iv, input int s, input logic [7:0] mpat, input int nt);
    @(negedge clk); ref_ok = 1'b0; tick = 1'b0;
    @(negedge clk); chk("R5", 1'b0, 1'b0); ref_ok = 1'b1;
    @(negedge clk); chk("R1", 1'b0, 1'b0);
    tick = 1'b1; ovl = mpat[0]; ival = 8'(iv);
    for (int n = 0; n < nt; n++) begin
      logic m;
      int   len;
      m   = mpat[n % 8];
      len = iv + (m ? OVL_OFS : DEAD_OFS);
      for (int t = 0; t < s; t++) begin
        logic win, pl, ep, el;
        string req;
        @(negedge clk);
        win = (n > 0) && (t < len);
        pl  = (n % 2) == 1;
        ep  = win ? m : !pl;
        el  = win ? m : pl;
        if (n == 0)      req = "R1";
        else if (win && iv > s) req = "R7";
        else if (win)    req = m ? "R4" : "R3";
        else             req = (t == len) ? "R2" : "R8";
        chk(req, ep, el);
        if (t == s - 1 && n < nt - 1) begin
          tick = 1'b1; ovl = mpat[(n + 1) % 8]; ival = 8'(iv);
        end else begin
          // R6: junk between ticks must not matter
          tick = 1'b0; ovl = ~m; ival = 8'(iv) ^ 8'h5A;
        end
      end
    end
    tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk); chk("R1", 1'b0, 1'b0);

    foreach (ival[i]) ; // no-op keeps loop style uniform
    for (int a = 0; a < 5; a++) begin
      int ivs[5] = '{0, 1, 2, 5, 7};
      for (int b = 0; b < 3; b++) begin
        int ss[3] = '{4, 9, 12};
        for (int c = 0; c < 3; c++) begin
          logic [7:0] pats[3] = '{8'h00, 8'hFF, 8'hA5};
          run_seq(ivs[a], ss[b], pats[c], 6);
        end
      end
    end
    // R7: window longer than or equal to tick spacing
    run_seq(20, 5, 8'hFF, 6);
    run_seq(20, 5, 8'h3C, 8);
    run_seq(2, 5, 8'h00, 6);

    // R5: tick together with ref drop, then ticks ignored while low
    run_seq(1, 6, 8'hFF, 3);
    @(negedge clk); ref_ok = 1'b0; tick = 1'b1;
    @(negedge clk); chk("R5", 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R5", 1'b0, 1'b0);
    end
    tick = 1'b0; ref_ok = 1'b1;
    @(negedge clk); chk("R1", 1'b0, 1'b0);
    tick = 1'b1; ovl = 1'b1; ival = 8'd4;
    @(negedge clk); tick = 1'b0; chk("R1", 1'b1, 1'b0);
    @(negedge clk); chk("R1", 1'b1, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule